// File: doc/BRIEF.md
# Write-Only Serial Control Slave

This block is a receive-only slave on a two-wire serial bus (clock line plus open-drain data line). It loads a small bank of control bits: one enable per clock output and a single test-mode enable. Both bus lines are oversampled by a fast system clock, which must run at least 8 times the bus clock rate. The block detects start and stop conditions, matches its own write address, and acknowledges each byte by raising a pull-down enable for the data line.

After the address, the bus master always sends two placeholder bytes whose contents are discarded. The control bytes follow in a fixed order, and there is no way to address a byte directly. A byte takes effect as soon as it is acknowledged, so a transfer that stops early updates only the bytes it reached. The bank cannot be read over the bus. Its contents are presented continuously on the output pins.

Top module: `wo_ctrl_slave`

## Requirements
- R1: After reset, every bit of `clk_en` is 1, `test_mode` is 0 and `sda_pull_low` is 0.
- R2: A first byte of 0xD2 after a start condition (7-bit address 0x69, MSB first, with the last bit 0 for write) is acknowledged. `sda_pull_low` is 1 while SCLK is high during the ninth clock, and it returns to 0 after that clock's falling edge.
- R3: A first byte with a different address, or with the read bit set (0xD3), is not acknowledged. Every later byte up to the next start condition is then not acknowledged and changes no output.
- R4: The two bytes after an acknowledged address (command and count) are acknowledged, and their contents change no output.
- R5: Control byte k (k = 0, 1, ...) is the (k+4)th byte of the transfer, counting the address byte, and is sent MSB first. Bit b of control byte k loads flat bit 8k+b. Flat bits 0 to NUM_CLK-1 are `clk_en[0..NUM_CLK-1]`, and flat bit NUM_CLK is `test_mode`.
- R6: A control byte takes effect when it is acknowledged. If a transfer ends before a control byte is sent, that byte keeps its value.
- R7: Bytes beyond the last implemented control byte are acknowledged and change no output.
- R8: A repeated start at any point restarts the address phase and releases `sda_pull_low`.
- R9: A stop condition releases `sda_pull_low` and ends the transfer. `sda_pull_low` never rises while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line as seen on the wire |
| sda_pull_low | output | 1 | Pull-down enable for the open-drain data line |
| clk_en | output | NUM_CLK | Per-output clock enables |
| test_mode | output | 1 | Test-mode enable |

## Verification
The assertions assume that the master keeps each SCLK phase several system clocks long. They also assume that SDATA changes only while SCLK is low, except for deliberate start and stop conditions, and that no start or stop is issued while the slave is acknowledging. Under these assumptions the pull-down only moves while SCLK is low. The bench master holds each quarter of an SCLK period for four system clocks and changes data in the middle of the low phase. Its repeated starts come only after the ninth clock has fallen, so every random and directed transfer stays within these assumptions.

// File: rtl/wo_ctrl_slave_pkg.sv
package wo_ctrl_slave_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_DATA,
    PH_DATA_ACK,
    PH_IGNORE
  } phase_t;

  function automatic int ctrl_byte_count(input int n_clk);
    return (n_clk + 8) / 8;
  endfunction
endpackage

// File: rtl/wo_sync.sv
module wo_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '1;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/wo_bus_cond.sv
module wo_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wo_byte_fsm.sv
module wo_byte_fsm
  import wo_ctrl_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         CTRL_BYTES = 2,
  parameter int         PREFIX     = 2,
  localparam int        IDXW       = $clog2(CTRL_BYTES + PREFIX + 1),
  localparam int        CIW        = (CTRL_BYTES > 1) ? $clog2(CTRL_BYTES) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sda_s,
  input  logic           scl_rise,
  input  logic           scl_fall,
  input  logic           start_det,
  input  logic           stop_det,
  output logic           wr_en,
  output logic [CIW-1:0] wr_idx,
  output logic [7:0]     wr_data,
  output logic           pull_low
);
  localparam logic [IDXW-1:0] IDX_MAX = IDXW'(CTRL_BYTES + PREFIX);
  localparam logic [IDXW-1:0] IDX_PRE = IDXW'(PREFIX);

  phase_t          phase;
  logic [3:0]      bit_cnt;
  logic [7:0]      shreg;
  logic [IDXW-1:0] byte_idx;
  logic [IDXW-1:0] rel_idx;
  logic            byte_full;

  assign rel_idx   = byte_idx - IDX_PRE;
  assign byte_full = (bit_cnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      pull_low <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase    <= PH_ADDR;
        bit_cnt  <= '0;
        byte_idx <= '0;
        pull_low <= 1'b0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        pull_low <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR, PH_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && byte_full) begin
              if (phase == PH_ADDR) begin
                if (shreg == {DEV_ADDR, 1'b0}) begin
                  phase    <= PH_ADDR_ACK;
                  pull_low <= 1'b1;
                end else begin
                  phase <= PH_IGNORE;
                end
              end else begin
                phase    <= PH_DATA_ACK;
                pull_low <= 1'b1;
                if (byte_idx >= IDX_PRE && byte_idx < IDX_MAX) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= rel_idx[CIW-1:0];
                  wr_data <= shreg;
                end
                if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
              end
            end
          end
          PH_ADDR_ACK, PH_DATA_ACK: begin
            if (scl_fall) begin
              phase    <= PH_DATA;
              pull_low <= 1'b0;
              bit_cnt  <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wo_reg_bank.sv
module wo_reg_bank #(
  parameter int  NUM_CLK    = 12,
  parameter int  CTRL_BYTES = 2,
  localparam int CIW        = (CTRL_BYTES > 1) ? $clog2(CTRL_BYTES) : 1,
  localparam int NBITS      = NUM_CLK + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CIW-1:0]   wr_idx,
  input  logic [7:0]       wr_data,
  output logic [NBITS-1:0] flat
);
  generate
    for (genvar j = 0; j < NBITS; j++) begin : g_bit
      localparam logic       RST_VAL = (j < NUM_CLK) ? 1'b1 : 1'b0;
      localparam logic [CIW-1:0] SEL = CIW'(j / 8);
      always_ff @(posedge clk) begin
        if (rst) flat[j] <= RST_VAL;
        else if (wr_en && wr_idx == SEL) flat[j] <= wr_data[j % 8];
      end
    end
  endgenerate
endmodule

// File: rtl/wo_ctrl_slave.sv
module wo_ctrl_slave
  import wo_ctrl_slave_pkg::*;
#(
  parameter int         NUM_CLK  = 12,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull_low,
  output logic [NUM_CLK-1:0] clk_en,
  output logic               test_mode
);
  localparam int CTRL_BYTES = ctrl_byte_count(NUM_CLK);
  localparam int CIW        = (CTRL_BYTES > 1) ? $clog2(CTRL_BYTES) : 1;

  logic [1:0]       sync_q;
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [CIW-1:0]   wr_idx;
  logic [7:0]       wr_data;
  logic [NUM_CLK:0] ctrl_flat;

  wo_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  wo_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  wo_byte_fsm #(.DEV_ADDR(DEV_ADDR), .CTRL_BYTES(CTRL_BYTES), .PREFIX(2)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pull_low(sda_pull_low)
  );

  wo_reg_bank #(.NUM_CLK(NUM_CLK), .CTRL_BYTES(CTRL_BYTES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .flat(ctrl_flat)
  );

  assign clk_en    = ctrl_flat[NUM_CLK-1:0];
  assign test_mode = ctrl_flat[NUM_CLK];
endmodule

// File: rtl/wo_ctrl_slave_chk.sv
module wo_ctrl_slave_chk #(
  parameter int NUM_CLK = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_in,
  input logic             sda_pull_low,
  input logic             start_det,
  input logic             stop_det,
  input logic [NUM_CLK:0] ctrl_flat
);
  assert_ack_rise_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> !scl_in);

  assert_ack_fall_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_pull_low) && !$past(start_det) && !$past(stop_det)) |-> !scl_in);

  assert_restart_release_R8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull_low);

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_low);

  assert_write_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_flat) |-> sda_pull_low);
endmodule

bind wo_ctrl_slave wo_ctrl_slave_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_pull_low(sda_pull_low),
  .start_det(start_det), .stop_det(stop_det), .ctrl_flat(ctrl_flat)
);

// File: tb/wo_ctrl_slave_bench.sv
module wo_ctrl_slave_bench;
  localparam int NUM_CLK = 12;
  localparam int CB      = (NUM_CLK + 8) / 8;
  localparam int Q       = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_wire;
  logic sda_pull_low;
  logic [NUM_CLK-1:0] clk_en;
  logic test_mode;

  int n_chk = 0;
  int n_bad = 0;
  logic [NUM_CLK:0] exp_bits;
  logic [7:0] tx [0:7];

  always #5 clk = ~clk;
  assign sda_wire = m_sda & ~sda_pull_low;

  wo_ctrl_slave #(.NUM_CLK(NUM_CLK)) u_wo_ctrl_slave (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_wire),
    .sda_pull_low(sda_pull_low), .clk_en(clk_en), .test_mode(test_mode)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (m_scl) begin m_scl = 1'b0; wq(1); end
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(2);
    m_sda = 1'b0; wq(2);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(1);
    m_scl = 1'b1; wq(2);
    m_sda = 1'b1; wq(3);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b0; wq(1);
      m_sda = d[i]; wq(1);
      m_scl = 1'b1; wq(2);
    end
    m_scl = 1'b0; wq(1);
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    ack = !sda_wire;
    wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  function automatic logic [NUM_CLK:0] apply_byte(input logic [NUM_CLK:0] cur, input int k, input logic [7:0] d);
    logic [NUM_CLK:0] r = cur;
    for (int j = 0; j <= NUM_CLK; j++)
      if (j / 8 == k) r[j] = d[j % 8];
    return r;
  endfunction

  task automatic xfer(input logic [7:0] addr, input int nb, input bit do_stop);
    bit ack;
    bit exp_ack;
    bus_start();
    send_byte(addr, ack);
    exp_ack = (addr == 8'hD2);
    check(ack == exp_ack, exp_ack ? "R2 address ack" : "R3 address nack", ack, exp_ack);
    check(sda_pull_low == 1'b0, "R2 release after ninth clock", sda_pull_low, 0);
    for (int i = 0; i < nb; i++) begin
      send_byte(tx[i], ack);
      if (!exp_ack)
        check(ack == 1'b0, "R3 ignored byte nack", ack, 0);
      else if (i < 2)
        check(ack == 1'b1, "R4 prefix ack", ack, 1);
      else if (i - 2 < CB) begin
        check(ack == 1'b1, "R5 control ack", ack, 1);
        exp_bits = apply_byte(exp_bits, i - 2, tx[i]);
      end else
        check(ack == 1'b1, "R7 surplus ack", ack, 1);
      check({test_mode, clk_en} == exp_bits, "R6 registers after byte", {test_mode, clk_en}, exp_bits);
    end
    if (do_stop) begin
      bus_stop();
      check(sda_pull_low == 1'b0, "R9 released after stop", sda_pull_low, 0);
    end
    check({test_mode, clk_en} == exp_bits, "R5 registers after transfer", {test_mode, clk_en}, exp_bits);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    exp_bits = {1'b0, {NUM_CLK{1'b1}}};
    check(clk_en == {NUM_CLK{1'b1}}, "R1 enables reset", clk_en, {NUM_CLK{1'b1}});
    check(test_mode == 1'b0, "R1 test reset", test_mode, 0);
    check(sda_pull_low == 1'b0, "R1 pull reset", sda_pull_low, 0);

    // R5 full write, bit mapping
    tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h5A; tx[3] = 8'h1F;
    xfer(8'hD2, 4, 1'b1);
    check(test_mode == 1'b1, "R5 test bit", test_mode, 1);
    // R4 prefix contents ignored: only prefixes sent
    tx[0] = 8'h00; tx[1] = 8'h00;
    xfer(8'hD2, 2, 1'b1);
    // R6 partial transfer: only first control byte
    tx[2] = 8'hFF;
    xfer(8'hD2, 3, 1'b1);
    // R7 surplus bytes
    tx[2] = 8'h81; tx[3] = 8'h00; tx[4] = 8'hFF; tx[5] = 8'h77;
    xfer(8'hD2, 6, 1'b1);
    // R3 read bit and mismatched address
    tx[2] = 8'h00; tx[3] = 8'h1F;
    xfer(8'hD3, 4, 1'b1);
    xfer(8'hD0, 4, 1'b1);
    // R8 repeated start mid-transfer
    tx[2] = 8'hC3;
    xfer(8'hD2, 2, 1'b0);
    xfer(8'hD2, 3, 1'b1);
    xfer(8'h12, 1, 1'b0);
    tx[3] = 8'h10;
    xfer(8'hD2, 4, 1'b1);

    for (int t = 0; t < 30; t++) begin
      logic [7:0] a;
      int nb;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
      nb = $urandom % 7;
      for (int i = 0; i < 8; i++) tx[i] = 8'($urandom);
      xfer(a, nb, ($urandom % 5) != 0);
    end
    bus_stop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule